// File: doc/BRIEF.md
# Masked Data Breakpoint Matcher

This block watches the data accesses of a processor core and decides whether any of them should raise a data breakpoint. It holds no breakpoint state of its own. A set of breakpoint pairs (two by default) arrives on input buses, and each pair is an address word plus a control word. For every valid access, the block checks the access address, its size (1, 2 or 4 bytes) and its direction (load or store) against every pair. One clock later it reports whether any pair hit and which pair it was.

A hit does not need the two addresses to be equal. The accessed bytes and the breakpoint region are compared for overlap. The control word carries a six-bit mask over the low address bits. The mask widens the breakpoint into an aligned region of up to 64 bytes. The access size widens the access into its naturally aligned block of bytes. A hit occurs when the access block and the breakpoint region share at least one byte. Both addresses are then compared under the combined mask, and every address bit from bit 6 upward must be equal.

Exception sequencing, cause reporting and the memory system are handled elsewhere. The surrounding pipeline samples `hit_o` and `hit_idx_o` in the cycle after it presents the access.

Top module: `dbm_matcher`

## Requirements
- R1: Control bit 30 enables matching on loads (`acc_store_i`=0) and control bit 31 enables matching on stores (`acc_store_i`=1). An access whose direction is not enabled never hits that pair.
- R2: Control bits 5:0 form a compare mask over address bits 5:0, where a 1 compares that bit and a 0 ignores it. Mask 0x3f gives a one-byte region, 0x3e 2 bytes, 0x3c 4 bytes, 0x38 8 bytes, 0x30 16 bytes and 0x20 32 bytes.
- R3: `acc_size_i` encodes 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes, and code 3 behaves as 4 bytes. The access covers the naturally aligned block of that size that contains `acc_addr_i`. It hits when any byte of that block lies in the breakpoint region.
- R4: A wide access that covers a smaller region hits. A narrow access that lies inside a larger region also hits.
- R5: Breakpoint address bits that the mask ignores have no effect on matching. A non-contiguous mask is applied bit by bit.
- R6: Address bits from bit 6 up to the top are always compared exactly.
- R7: A pair whose control word is 0 never hits.
- R8: When several pairs hit together, `hit_idx_o` gives the lowest index. While `hit_o` is 0, `hit_idx_o` is 0.
- R9: Results are registered. `hit_o` is 1 in the cycle after a valid access that hit, and it is 1 only in that cycle. An access with `acc_valid_i`=0 never produces a hit.
- R10: Synchronous active-high reset clears `hit_o` and `hit_idx_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| acc_size_i | input | 2 | Size code: 0=1, 1=2, 2 or 3=4 bytes |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| bp_addr_i | input | NUM_BP*ADDR_W | Breakpoint addresses, pair n at bits n*ADDR_W upward |
| bp_ctl_i | input | NUM_BP*32 | Control words: bit 31 store enable, bit 30 load enable, bits 5:0 mask |
| hit_o | output | 1 | Some pair hit the access of the previous cycle |
| hit_idx_o | output | IDX_W | Lowest index of the pairs that hit |

## Verification
Some properties are checked by assertions on every cycle. A hit must follow a valid access. The index must read zero when there is no hit. A pair with a zero control word must never win. An access in a direction that is disabled must never match, and the winning pair must be the lowest one requesting. The bench scenarios cover the behaviour that depends on arithmetic over addresses, which no simple property can state: overlap between byte blocks of different sizes, regions built from contiguous and non-contiguous masks, breakpoint address bits that the mask ignores, and the exact compare of the upper bits. A full sweep of access offsets and sizes against a byte-by-byte model shows that the mask-based compare equals a true range overlap.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    localparam int CTL_W    = 32;
    localparam int MASK_W   = 6;
    localparam int LD_BIT   = 30;
    localparam int ST_BIT   = 31;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              st_en;
        logic              ld_en;
        logic [MASK_W-1:0] mask;
    } ctl_fields_t;

    function automatic ctl_fields_t decode_ctl(input logic [CTL_W-1:0] ctl);
        ctl_fields_t f;
        f.st_en = ctl[ST_BIT];
        f.ld_en = ctl[LD_BIT];
        f.mask  = ctl[MASK_W-1:0];
        return f;
    endfunction

    // Clears the low bits that an access of the given size spans.
    function automatic logic [MASK_W-1:0] size_align(input acc_size_e sz);
        logic [MASK_W-1:0] m;
        case (sz)
            SZ_BYTE: m = 6'h3f;
            SZ_HALF: m = 6'h3e;
            default: m = 6'h3c;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dbm_slot.sv
module dbm_slot
    import dbm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [1:0]        acc_size_i,
    input  logic              acc_store_i,
    input  logic [ADDR_W-1:0] bp_addr_i,
    input  logic [CTL_W-1:0]  bp_ctl_i,
    output logic              match_o
);

    ctl_fields_t       fld;
    logic [MASK_W-1:0] cmp_mask;
    logic              low_eq;
    logic              high_eq;
    logic              dir_en;
    logic              unused_ctl_bits;

    assign fld             = decode_ctl(bp_ctl_i);
    assign unused_ctl_bits = ^bp_ctl_i[LD_BIT-1:MASK_W];

    always_comb begin
        cmp_mask = fld.mask & size_align(acc_size_e'(acc_size_i));
        low_eq   = ((acc_addr_i[MASK_W-1:0] ^ bp_addr_i[MASK_W-1:0]) & cmp_mask) == '0;
        high_eq  = acc_addr_i[ADDR_W-1:MASK_W] == bp_addr_i[ADDR_W-1:MASK_W];
        dir_en   = acc_store_i ? fld.st_en : fld.ld_en;
        match_o  = dir_en && low_eq && high_eq;
    end

    always_comb begin
        // R1
        dir_gate_chk: assert (!match_o || (acc_store_i ? bp_ctl_i[ST_BIT] : bp_ctl_i[LD_BIT]));
    end

endmodule

// File: rtl/dbm_prio.sv
module dbm_prio #(
    parameter int N     = 2,
    parameter int IDX_W = 1
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    always_comb begin
        // R8
        lowest_win_chk: assert (!any_o || (req_i[idx_o] &&
                         ((req_i & ((N'(1) << idx_o) - N'(1))) == '0)));
    end

endmodule

// File: rtl/dbm_matcher.sv
module dbm_matcher
    import dbm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_BP = 2,
    localparam int IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     acc_valid_i,
    input  logic [ADDR_W-1:0]        acc_addr_i,
    input  logic [1:0]               acc_size_i,
    input  logic                     acc_store_i,
    input  logic [NUM_BP*ADDR_W-1:0] bp_addr_i,
    input  logic [NUM_BP*CTL_W-1:0]  bp_ctl_i,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         hit_idx_o
);

    logic [NUM_BP-1:0] slot_match;
    logic [NUM_BP-1:0] slot_req;
    logic              any_hit;
    logic [IDX_W-1:0]  win_idx;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
        dbm_slot #(.ADDR_W(ADDR_W)) u_slot (
            .acc_addr_i (acc_addr_i),
            .acc_size_i (acc_size_i),
            .acc_store_i(acc_store_i),
            .bp_addr_i  (bp_addr_i[g*ADDR_W +: ADDR_W]),
            .bp_ctl_i   (bp_ctl_i[g*CTL_W +: CTL_W]),
            .match_o    (slot_match[g])
        );
    end

    assign slot_req = slot_match & {NUM_BP{acc_valid_i}};

    dbm_prio #(.N(NUM_BP), .IDX_W(IDX_W)) u_prio (
        .req_i(slot_req),
        .any_o(any_hit),
        .idx_o(win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o     <= 1'b0;
            hit_idx_o <= '0;
        end else begin
            hit_o     <= any_hit;
            hit_idx_o <= any_hit ? win_idx : '0;
        end
    end

    // R9
    hit_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> $past(acc_valid_i));

    // R8
    idle_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> hit_idx_o == '0);

    // R7
    zero_ctl_never_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && bp_ctl_i[CTL_W-1:0] == '0) |=> (!hit_o || hit_idx_o != '0));

endmodule

// File: tb/test_dbm_matcher.sv
`timescale 1ns/1ps
module test_dbm_matcher;

    localparam int ADDR_W = 32;
    localparam int NUM_BP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid_i = 1'b0;
    logic [31:0] acc_addr_i = '0;
    logic [1:0]  acc_size_i = '0;
    logic        acc_store_i = 1'b0;
    logic [63:0] bp_addr_i = '0;
    logic [63:0] bp_ctl_i = '0;
    logic        hit_o;
    logic        hit_idx_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dbm_matcher #(.ADDR_W(ADDR_W), .NUM_BP(NUM_BP)) i_dbm_matcher (
        .clk(clk), .rst(rst), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
        .acc_size_i(acc_size_i), .acc_store_i(acc_store_i), .bp_addr_i(bp_addr_i),
        .bp_ctl_i(bp_ctl_i), .hit_o(hit_o), .hit_idx_o(hit_idx_o)
    );

    localparam logic [31:0] BASE = 32'h4a00_1200;

    task automatic set_bp(input int n, input logic [31:0] a, input logic [31:0] c);
        bp_addr_i[n*32 +: 32] = a;
        bp_ctl_i[n*32 +: 32]  = c;
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic st);
        @(negedge clk);
        acc_addr_i  = a;
        acc_size_i  = sz;
        acc_store_i = st;
        acc_valid_i = 1'b1;
        @(negedge clk);
        acc_valid_i = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic eh, input logic ei);
        checks++;
        if (hit_o !== eh || hit_idx_o !== ei) begin
            errors++;
            $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d",
                     tag, hit_o, hit_idx_o, eh, ei);
        end
    endtask

    // Byte-by-byte overlap model.
    function automatic bit model_hit(input logic [31:0] a, input logic [1:0] sz,
                                     input logic st, input logic [31:0] bpa,
                                     input logic [31:0] c);
        int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        logic [31:0] base = a & ~(32'(nb) - 32'd1);
        bit en = st ? c[31] : c[30];
        for (int b = 0; b < nb; b++)
            if ((((base + 32'(b)) ^ bpa) & {26'h3ffffff, c[5:0]}) == 32'd0) return en;
        return 1'b0;
    endfunction

    task automatic t_reset();
        expect_out("R10 reset state", 1'b0, 1'b0);
    endtask

    task automatic t_direction();
        set_bp(1, 32'd0, 32'd0);
        set_bp(0, BASE + 32'h10, 32'h4000_003f);
        access(BASE + 32'h10, 2'd0, 1'b1); expect_out("R1 store on load-only", 1'b0, 1'b0);
        access(BASE + 32'h10, 2'd0, 1'b0); expect_out("R1 load on load-only", 1'b1, 1'b0);
        set_bp(0, BASE + 32'h10, 32'h8000_003f);
        access(BASE + 32'h10, 2'd0, 1'b0); expect_out("R1 load on store-only", 1'b0, 1'b0);
        access(BASE + 32'h10, 2'd0, 1'b1); expect_out("R1 store on store-only", 1'b1, 1'b0);
    endtask

    task automatic t_overlap();
        set_bp(0, BASE + 32'h7d, 32'h4000_003f);
        access(BASE + 32'h7c, 2'd2, 1'b0); expect_out("R4 word covers byte bp", 1'b1, 1'b0);
        access(BASE + 32'h7c, 2'd1, 1'b0); expect_out("R3 half covers byte bp", 1'b1, 1'b0);
        access(BASE + 32'h7c, 2'd0, 1'b0); expect_out("R2 adjacent byte misses", 1'b0, 1'b0);
        access(BASE + 32'h7c, 2'd3, 1'b0); expect_out("R3 size code 3 as word", 1'b1, 1'b0);
        set_bp(0, BASE + 32'h7c, 32'h4000_003c);
        access(BASE + 32'h7f, 2'd0, 1'b0); expect_out("R4 byte inside 4-byte region", 1'b1, 1'b0);
        access(BASE + 32'h80, 2'd0, 1'b0); expect_out("R2 byte past 4-byte region", 1'b0, 1'b0);
        set_bp(0, BASE + 32'h60, 32'h4000_0020);
        access(BASE + 32'h74, 2'd2, 1'b0); expect_out("R2 word in 32-byte region", 1'b1, 1'b0);
        access(BASE + 32'h40, 2'd1, 1'b0); expect_out("R2 half outside 32-byte region", 1'b0, 1'b0);
    endtask

    task automatic t_sweep();
        set_bp(0, BASE + 32'h2a, 32'h4000_0038);
        for (int sz = 0; sz < 3; sz++) begin
            for (int off = 0; off < 64; off++) begin
                logic [31:0] a = BASE + 32'(off);
                logic exp_h = model_hit(a, 2'(sz), 1'b0, BASE + 32'h2a, 32'h4000_0038);
                access(a, 2'(sz), 1'b0);
                expect_out("R3 overlap sweep", exp_h, 1'b0);
            end
        end
    endtask

    task automatic t_ignored_bits();
        set_bp(0, BASE + 32'h71, 32'h4000_0030);
        access(BASE + 32'h70, 2'd1, 1'b0); expect_out("R5 ignored bp bits", 1'b1, 1'b0);
        set_bp(0, BASE + 32'h72, 32'h4000_0035);
        access(BASE + 32'h70, 2'd2, 1'b0); expect_out("R5 sparse mask word", 1'b1, 1'b0);
        access(BASE + 32'h78, 2'd0, 1'b0); expect_out("R5 sparse mask bit3 ignored", 1'b1, 1'b0);
        access(BASE + 32'h71, 2'd0, 1'b0); expect_out("R5 sparse mask bit0 compared", 1'b0, 1'b0);
    endtask

    task automatic t_high_bits();
        set_bp(0, BASE + 32'h60, 32'h4000_0020);
        access(BASE + 32'h160, 2'd0, 1'b0); expect_out("R6 bit8 differs", 1'b0, 1'b0);
        access((BASE + 32'h60) ^ 32'h8000_0000, 2'd0, 1'b0); expect_out("R6 bit31 differs", 1'b0, 1'b0);
        set_bp(0, BASE + 32'h3f, 32'h4000_0000);
        access(BASE + 32'h00, 2'd2, 1'b0); expect_out("R6 zero mask same block", 1'b1, 1'b0);
        access(BASE + 32'h40, 2'd2, 1'b0); expect_out("R6 zero mask next block", 1'b0, 1'b0);
    endtask

    task automatic t_disable();
        set_bp(0, BASE + 32'h20, 32'd0);
        set_bp(1, BASE + 32'h20, 32'd0);
        access(BASE + 32'h20, 2'd0, 1'b0); expect_out("R7 disabled load", 1'b0, 1'b0);
        access(BASE + 32'h20, 2'd2, 1'b1); expect_out("R7 disabled store", 1'b0, 1'b0);
        set_bp(1, BASE + 32'h20, 32'h4000_003f);
        access(BASE + 32'h20, 2'd0, 1'b0); expect_out("R7 pair0 off pair1 on", 1'b1, 1'b1);
    endtask

    task automatic t_priority();
        set_bp(0, BASE + 32'h20, 32'hc000_003c);
        set_bp(1, BASE + 32'h22, 32'hc000_003f);
        access(BASE + 32'h22, 2'd0, 1'b1); expect_out("R8 both hit lowest wins", 1'b1, 1'b0);
        access(BASE + 32'h22, 2'd0, 1'b0); expect_out("R8 both hit on load", 1'b1, 1'b0);
        set_bp(0, BASE + 32'h30, 32'hc000_003c);
        access(BASE + 32'h22, 2'd0, 1'b0); expect_out("R8 only pair1", 1'b1, 1'b1);
        access(BASE + 32'h10, 2'd0, 1'b0); expect_out("R8 no hit idx zero", 1'b0, 1'b0);
    endtask

    task automatic t_timing();
        set_bp(0, BASE + 32'h08, 32'h4000_003f);
        set_bp(1, 32'd0, 32'd0);
        @(negedge clk);
        acc_addr_i = BASE + 32'h08; acc_size_i = 2'd0; acc_store_i = 1'b0; acc_valid_i = 1'b0;
        @(negedge clk);
        expect_out("R9 no valid no hit", 1'b0, 1'b0);
        access(BASE + 32'h08, 2'd0, 1'b0); expect_out("R9 hit next cycle", 1'b1, 1'b0);
        @(negedge clk);
        expect_out("R9 hit lasts one cycle", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direction();
        t_overlap();
        t_sweep();
        t_ignored_bits();
        t_high_bits();
        t_disable();
        t_priority();
        t_timing();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule